// File: doc/BRIEF.md
# Configurable Aspect Dual-Port Memory Bank

This block is a bank of 256-bit storage tiles. Each tile has one write port and one read port, and the two ports run on separate clocks. A static mode input sets how each tile is organised: as 32 words of 8 bits (byte mode) or as 64 words of 4 bits (narrow mode). In narrow mode, two 4-bit words share each physical byte.

Each port has its own edge-select input, so it can capture on the rising or the falling edge of its clock. Writes are qualified by a write enable. Read data is registered on the active read edge.

Tiles are placed in a grid set by two parameters. `WIDE` tiles side by side widen the data buses by 8 bits each. `DEEP` rows of tiles extend the address: the address bits above bit 5 pick the row.

Top module: `aspect_ram_bank`

## Requirements
- R1: In byte mode (`narrow`=0) a write with `we`=1 stores each 8-bit lane c of `wdata` (bits 8c+7..8c) into byte `waddr[4:0]` of tile column c. A later read of that address returns the byte on the same lane of `rdata`.
- R2: In byte mode, address bit 5 of both ports is ignored. Addresses that differ only in bit 5 reach the same byte.
- R3: In narrow mode, word A of a tile lives in byte A[5:1]: in bits 3..0 when A[0]=0 and in bits 7..4 when A[0]=1. A write stores `wdata[8c+3:8c]` there. A read returns the word on `rdata[8c+3:8c]`, and `rdata[8c+7:8c+4]` reads 0.
- R4: A narrow-mode write leaves the other nibble of the addressed byte unchanged.
- R5: A write edge with `we`=0 changes no stored data.
- R6: `rdata` is loaded on the active read edge from the location `raddr` gives at that edge. When a write and a read hit the same location on the same edge, the read returns the old contents.
- R7: `wclk_fall`=1 makes the write port capture on the falling edge of `wclk`, and 0 on the rising edge. `rclk_fall` does the same for `rclk` and the read port. The two settings are independent. Mode and edge settings are static while the clocks run.
- R8: With `DEEP`>1, address bits `AW-1..6` select the tile row. A write changes only the selected row, and a read returns data from the row its address selected.
- R9: All tile columns share the address. Lane c of `wdata` and `rdata` belongs only to column c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write port clock |
| wclk_fall | input | 1 | 1: write captures on falling edge of `wclk` |
| rclk | input | 1 | Read port clock |
| rclk_fall | input | 1 | 1: read captures on falling edge of `rclk` |
| narrow | input | 1 | 0: 32x8 per tile, 1: 64x4 per tile |
| we | input | 1 | Write enable |
| waddr | input | AW (7) | Write address, row bits above bit 5 |
| wdata | input | 8*WIDE (16) | Write data, one byte lane per column |
| raddr | input | AW (7) | Read address, row bits above bit 5 |
| rdata | output | 8*WIDE (16) | Registered read data |

## Verification
A read result appears on `rdata` one active read edge after `raddr` is presented. A stored value reaches a read on the first read edge that comes after its write edge. On a shared edge, the read still returns the old data. The bench drives every input 1 ns after a rising edge and samples 4 ns later. Each step therefore contains exactly one falling and one rising edge, so each port captures once per step whatever its polarity. Within a step, the bench's model applies the write before the read only when the write edge is falling and the read edge is rising, because that is the only case in which the write edge comes first.

// File: rtl/aspect_ram_tile.sv
module aspect_ram_tile (
  input  logic       wclk,
  input  logic       wclk_fall,
  input  logic       rclk,
  input  logic       rclk_fall,
  input  logic       narrow,
  input  logic       we,
  input  logic [5:0] waddr,
  input  logic [7:0] wdata,
  input  logic [5:0] raddr,
  output logic [7:0] rdata
);
  logic       wck, rck;
  logic [7:0] mem [32];
  logic [4:0] wbyte, rbyte;
  logic [7:0] wmask, wnew, rword;

  assign wck   = wclk ^ wclk_fall;
  assign rck   = rclk ^ rclk_fall;
  assign wbyte = narrow ? waddr[5:1] : waddr[4:0];
  assign rbyte = narrow ? raddr[5:1] : raddr[4:0];
  assign wmask = !narrow ? 8'hFF : (waddr[0] ? 8'hF0 : 8'h0F);
  assign wnew  = narrow ? {2{wdata[3:0]}} : wdata;
  assign rword = mem[rbyte];

  always_ff @(posedge wck)
    if (we) mem[wbyte] <= (mem[wbyte] & ~wmask) | (wnew & wmask);

  always_ff @(posedge rck)
    rdata <= narrow ? {4'h0, (raddr[0] ? rword[7:4] : rword[3:0])} : rword;
endmodule

// File: rtl/aspect_ram_bank.sv
module aspect_ram_bank #(
  parameter  int WIDE = 2,
  parameter  int DEEP = 2,
  localparam int RB   = (DEEP > 1) ? $clog2(DEEP) : 0,
  localparam int AW   = 6 + RB,
  localparam int DW   = 8 * WIDE
) (
  input  logic          wclk,
  input  logic          wclk_fall,
  input  logic          rclk,
  input  logic          rclk_fall,
  input  logic          narrow,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0]   tile_rd [DEEP];
  logic [DEEP-1:0] row_we;

  for (genvar r = 0; r < DEEP; r++) begin : g_row
    if (DEEP > 1) begin : g_sel
      assign row_we[r] = we && (waddr[AW-1:6] == RB'(r));
    end else begin : g_one
      assign row_we[r] = we;
    end
    for (genvar c = 0; c < WIDE; c++) begin : g_col
      aspect_ram_tile u_tile (
        .wclk      (wclk),
        .wclk_fall (wclk_fall),
        .rclk      (rclk),
        .rclk_fall (rclk_fall),
        .narrow    (narrow),
        .we        (row_we[r]),
        .waddr     (waddr[5:0]),
        .wdata     (wdata[8*c +: 8]),
        .raddr     (raddr[5:0]),
        .rdata     (tile_rd[r][8*c +: 8])
      );
    end
  end

  if (DEEP > 1) begin : g_deep
    logic          rck;
    logic [RB-1:0] rsel_q;
    assign rck = rclk ^ rclk_fall;
    always_ff @(posedge rck) rsel_q <= raddr[AW-1:6];
    assign rdata = tile_rd[rsel_q];
  end else begin : g_flat
    assign rdata = tile_rd[0];
  end
endmodule

// File: rtl/aspect_ram_tile_chk.sv
module aspect_ram_tile_chk (
  input logic       wck,
  input logic       rck,
  input logic       narrow,
  input logic       we,
  input logic [5:0] waddr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] mem [32]
);
  logic [4:0] widx;
  assign widx = narrow ? waddr[5:1] : waddr[4:0];

  assert_hold_when_idle_R5: assert property (@(posedge wck)
    !we |=> mem[$past(widx)] === $past(mem[widx]));

  assert_byte_lands_low5_R2: assert property (@(posedge wck)
    (we && !narrow) |=> mem[$past(waddr[4:0])] === $past(wdata));

  assert_low_nibble_write_R3: assert property (@(posedge wck)
    (we && narrow && !waddr[0]) |=> mem[$past(widx)][3:0] === $past(wdata[3:0]));

  assert_high_nibble_write_R3: assert property (@(posedge wck)
    (we && narrow && waddr[0]) |=> mem[$past(widx)][7:4] === $past(wdata[3:0]));

  assert_keep_high_nibble_R4: assert property (@(posedge wck)
    (we && narrow && !waddr[0]) |=> mem[$past(widx)][7:4] === $past(mem[widx][7:4]));

  assert_keep_low_nibble_R4: assert property (@(posedge wck)
    (we && narrow && waddr[0]) |=> mem[$past(widx)][3:0] === $past(mem[widx][3:0]));

  assert_narrow_upper_zero_R3: assert property (@(posedge rck)
    narrow |=> rdata[7:4] === 4'h0);
endmodule

bind aspect_ram_tile aspect_ram_tile_chk u_chk (
  .wck(wck), .rck(rck), .narrow(narrow), .we(we), .waddr(waddr),
  .wdata(wdata), .rdata(rdata), .mem(mem)
);

// File: tb/sim_aspect_ram_bank.sv
module sim_aspect_ram_bank;
  localparam int WIDE = 2;
  localparam int DEEP = 2;
  localparam int AW   = 7;
  localparam int DW   = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          wfall = 1'b0, rfall = 1'b0, narrow = 1'b0, we = 1'b0;
  logic [AW-1:0] waddr = '0, raddr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  aspect_ram_bank #(.WIDE(WIDE), .DEEP(DEEP)) u0 (
    .wclk(clk), .wclk_fall(wfall), .rclk(clk), .rclk_fall(rfall),
    .narrow(narrow), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  logic [7:0]    model [DEEP][WIDE][32];
  logic [DW-1:0] exp_q;
  int total = 0, bad = 0;

  function automatic logic [DW-1:0] model_read(logic [AW-1:0] a, logic nm);
    logic [DW-1:0] res;
    logic [7:0] b;
    int r;
    r = int'(a >> 6);
    res = '0;
    for (int c = 0; c < WIDE; c++) begin
      b = model[r][c][nm ? a[5:1] : a[4:0]];
      res[8*c +: 8] = nm ? {4'h0, (a[0] ? b[7:4] : b[3:0])} : b;
    end
    return res;
  endfunction

  task automatic model_write(logic [AW-1:0] a, logic [DW-1:0] d, logic nm);
    int r;
    r = int'(a >> 6);
    for (int c = 0; c < WIDE; c++) begin
      if (!nm) model[r][c][a[4:0]] = d[8*c +: 8];
      else if (a[0]) model[r][c][a[5:1]][7:4] = d[8*c +: 4];
      else model[r][c][a[5:1]][3:0] = d[8*c +: 4];
    end
  endtask

  task automatic step(input logic w, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                      input logic [AW-1:0] ra, input string tag);
    we = w; waddr = wa; wdata = wd; raddr = ra;
    if (wfall && !rfall) begin
      if (w) model_write(wa, wd, narrow);
      exp_q = model_read(ra, narrow);
    end else begin
      exp_q = model_read(ra, narrow);
      if (w) model_write(wa, wd, narrow);
    end
    #4;
    if (tag != "") begin
      total++;
      if (rdata !== exp_q) begin
        bad++;
        $display("FAIL %s: rdata=%h expected=%h (raddr=%h)", tag, rdata, exp_q, ra);
      end
    end
  endtask

  task automatic setcfg(input logic nm, input logic wf, input logic rf);
    we = 1'b0; narrow = nm; wfall = wf; rfall = rf;
    #4;
  endtask

  task automatic rand_phase(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      step(1'($urandom), AW'($urandom), DW'($urandom), ($urandom % 3 == 0) ? a : AW'($urandom), tag);
    end
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog: run expired, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    @(posedge clk); #1;
    for (int r = 0; r < DEEP; r++)
      for (int i = 0; i < 32; i++)
        step(1'b1, AW'({r[0], 1'b0, i[4:0]}), DW'($urandom), '0, "");
    step(1'b0, '0, '0, 7'h05, "R1 readback row0");
    step(1'b0, '0, '0, 7'h45, "R1 readback row1");

    step(1'b1, 7'h23, 16'hA55A, 7'h00, "");
    step(1'b0, '0, '0, 7'h03, "R2 bit5 ignored on write");
    step(1'b0, '0, '0, 7'h23, "R2 bit5 ignored on read");

    step(1'b0, 7'h07, 16'h1234, 7'h07, "R5 disabled write");
    step(1'b0, '0, '0, 7'h07, "R5 contents unchanged");

    step(1'b1, 7'h09, 16'hBEEF, 7'h09, "R6 collision returns old");
    step(1'b0, '0, '0, 7'h09, "R6 new data next edge");

    step(1'b1, 7'h4A, 16'hC3C3, 7'h0A, "R8 other row read");
    step(1'b0, '0, '0, 7'h0A, "R8 row0 untouched");
    step(1'b0, '0, '0, 7'h4A, "R8 row1 written");
    step(1'b1, 7'h0B, 16'h7E81, 7'h0B, "");
    step(1'b0, '0, '0, 7'h0B, "R9 lanes independent");

    setcfg(1'b1, 1'b0, 1'b0);
    step(1'b1, 7'h0A, 16'h0705, 7'h0B, "R3 narrow read upper zero");
    step(1'b0, '0, '0, 7'h0A, "R3 narrow low nibble");
    step(1'b0, '0, '0, 7'h0B, "R4 high nibble kept");
    step(1'b1, 7'h0B, 16'h0209, 7'h0A, "R4 low nibble kept");
    step(1'b0, '0, '0, 7'h0B, "R3 narrow high nibble");
    step(1'b0, '0, '0, 7'h3F, "R3 top word");
    step(1'b0, '0, '0, 7'h7E, "R8 narrow row1");

    setcfg(1'b0, 1'b1, 1'b0);
    step(1'b1, 7'h11, 16'h5AA5, 7'h11, "R7 falling write before rising read");
    setcfg(1'b0, 1'b0, 1'b1);
    step(1'b1, 7'h12, 16'h6996, 7'h12, "R7 falling read before rising write");
    step(1'b0, '0, '0, 7'h12, "R7 falling read sees write");
    setcfg(1'b0, 1'b1, 1'b1);
    step(1'b1, 7'h13, 16'h0FF0, 7'h13, "R6 falling collision old");
    step(1'b0, '0, '0, 7'h13, "R7 both falling");

    setcfg(1'b0, 1'b0, 1'b0);
    rand_phase(200, "R1 random byte mode");
    setcfg(1'b1, 1'b0, 1'b0);
    rand_phase(200, "R3 random narrow mode");
    setcfg(1'b1, 1'b1, 1'b0);
    rand_phase(150, "R7 random write falling");
    setcfg(1'b0, 1'b0, 1'b1);
    rand_phase(150, "R7 random read falling");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule